// File: doc/BRIEF.md
# Delta-Modulated Level Generator

This block converts a stream of sample bytes into a 7-bit output level by delta modulation. A period timer, advanced once per CPU-cycle enable and programmed through a 4-bit rate index, produces a step pulse each time it expires. On each step the generator takes the low bit of its current byte and moves the level two codes up (bit = 1) or down (bit = 0), stopping short of the ends of the 7-bit range. Bytes are consumed in fixed frames of eight steps.

A frame cannot be cut short. At the last step of a frame the generator looks at the one-byte sample buffer outside the block. If the buffer is full it takes the byte and pulses a consume strobe, so the surrounding logic can empty the buffer. If the buffer is empty it plays a silent frame of eight steps that leaves the level unchanged. Software can overwrite the level at any time through a direct-load write.

Top module: `delta_level_unit`

## Requirements
- R1: After reset the level is 0 and the consume strobe is low. The generator starts in a silent frame, and the timer expires on the first CPU-cycle enable.
- R2: The timer period in CPU-cycle enables for rate index 0..15 is 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72, 54. Cycles without the enable do not advance the timer.
- R3: buf_take is high in exactly the cycle whose clock edge ends a frame while buf_full is high. The byte on buf_byte is captured at that edge. The strobe is low at all other times.
- R4: On a step whose bit is 1, the level rises by 2 only when it is below 126. So 124 goes to 126 and stays there, and 125 goes to 127 and stays there.
- R5: On a step whose bit is 0, the level falls by 2 only when it is above 1. So 3 goes to 1 and stays there, and 2 goes to 0 and stays there.
- R6: A byte is played least significant bit first, one bit per step, for exactly 8 steps.
- R7: If buf_full is low when a frame ends, the next frame is silent. Its 8 steps leave the level unchanged, and no byte is taken.
- R8: A buffer that becomes full partway through a frame is taken only at the end of that frame, never earlier.
- R9: A direct-load write (load_we high at an edge) sets the level to load_val at that edge. It wins over a step that falls on the same edge.
- R10: The level is a register output that changes only at the edge of a step or a direct load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_tick | input | 1 | CPU-cycle enable that advances the period timer |
| rate_idx | input | 4 | Rate table index |
| buf_byte | input | 8 | Byte held in the sample buffer |
| buf_full | input | 1 | Sample buffer holds a byte |
| load_we | input | 1 | Direct-load write strobe |
| load_val | input | 7 | Direct-load value |
| level | output | 7 | Current output level |
| buf_take | output | 1 | Consume strobe that empties the sample buffer |

## Verification
The hardest case to reach is a direct load that lands on the same edge as a timer step. The step edges cannot be seen at the ports unless the level moves. The bench therefore uses the consume strobe as a time reference: the edge that captures a byte is also a step edge, and the next step follows exactly one period later. The direct load is placed by counting cycles from that edge. The same cycle counting places a buffer fill in the middle of a frame, and checks that the take is delayed to the frame end.

// File: rtl/dlu_pkg.sv
package dlu_pkg;

    localparam int RATE_W  = 4;
    localparam int LEVEL_W = 7;
    localparam int BYTE_W  = 8;
    localparam int TMR_W   = 9;

    // Timer period in CPU-cycle enables for each rate index
    function automatic logic [TMR_W-1:0] rate_period(input logic [RATE_W-1:0] idx);
        logic [TMR_W-1:0] p;
        case (idx)
            4'h0:    p = 9'd428;
            4'h1:    p = 9'd380;
            4'h2:    p = 9'd340;
            4'h3:    p = 9'd320;
            4'h4:    p = 9'd286;
            4'h5:    p = 9'd254;
            4'h6:    p = 9'd226;
            4'h7:    p = 9'd214;
            4'h8:    p = 9'd190;
            4'h9:    p = 9'd160;
            4'hA:    p = 9'd142;
            4'hB:    p = 9'd128;
            4'hC:    p = 9'd106;
            4'hD:    p = 9'd84;
            4'hE:    p = 9'd72;
            default: p = 9'd54;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dlu_rate_timer.sv
module dlu_rate_timer
    import dlu_pkg::*;
#(
    parameter int RW = RATE_W,
    parameter int TW = TMR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_tick,
    input  logic [RW-1:0] rate_idx,
    output logic          fire
);

    typedef struct packed {
        logic [TW-1:0] count;
    } tmr_t;

    tmr_t    st_d, st_q;
    logic    fire_d;

    always_comb begin
        st_d   = st_q;
        fire_d = 1'b0;
        if (cpu_tick) begin
            if (st_q.count == '0) begin
                fire_d     = 1'b1;
                st_d.count = TW'(rate_period(RATE_W'(rate_idx)) - 9'd1);
            end else begin
                st_d.count = st_q.count - TW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.count <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire = fire_d;

    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_tick |=> $stable(st_q.count));  // R2
    AST_FIRE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> cpu_tick);  // R2
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count < TW'(428));  // R2

endmodule

// File: rtl/dlu_frame.sv
module dlu_frame
    import dlu_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic          buf_full,
    input  logic [BW-1:0] buf_byte,
    output logic          step_up,
    output logic          step_dn,
    output logic          buf_take
);

    localparam int CW = $clog2(BW + 1);

    typedef struct packed {
        logic [BW-1:0] shreg;
        logic [CW-1:0] left;
        logic          mute;
    } frame_t;

    frame_t st_d, st_q;
    logic   take_d;
    logic   last_bit;

    assign last_bit = (st_q.left == CW'(1));

    always_comb begin
        st_d   = st_q;
        take_d = 1'b0;
        if (fire) begin
            st_d.shreg = st_q.shreg >> 1;
            st_d.left  = st_q.left - CW'(1);
            if (last_bit) begin
                st_d.left = CW'(BW);
                if (buf_full) begin
                    st_d.mute  = 1'b0;
                    st_d.shreg = buf_byte;
                    take_d     = 1'b1;
                end else begin
                    st_d.mute  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.shreg <= '0;
            st_q.left  <= CW'(BW);
            st_q.mute  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign step_up  = fire && !st_q.mute &&  st_q.shreg[0];
    assign step_dn  = fire && !st_q.mute && !st_q.shreg[0];
    assign buf_take = take_d;

    AST_TAKE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        buf_take |-> (fire && buf_full));  // R3
    AST_BITS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.left != '0) && (st_q.left <= CW'(BW)));  // R6
    AST_MUTE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mute |-> (!step_up && !step_dn));  // R7
    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire) |=> $stable(st_q.left));  // R8

endmodule

// File: rtl/dlu_level.sv
module dlu_level
    import dlu_pkg::*;
#(
    parameter int LW = LEVEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_we,
    input  logic [LW-1:0] load_val,
    input  logic          step_up,
    input  logic          step_dn,
    output logic [LW-1:0] level
);

    localparam logic [LW-1:0] STEP   = LW'(2);
    localparam logic [LW-1:0] UP_LIM = LW'((1 << LW) - 2);
    localparam logic [LW-1:0] DN_LIM = LW'(1);

    typedef struct packed {
        logic [LW-1:0] lvl;
    } lvl_t;

    lvl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_we) begin
            st_d.lvl = load_val;
        end else if (step_up && (st_q.lvl < UP_LIM)) begin
            st_d.lvl = st_q.lvl + STEP;
        end else if (step_dn && (st_q.lvl > DN_LIM)) begin
            st_d.lvl = st_q.lvl - STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lvl <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.lvl;

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> (level == $past(load_val)));  // R9
    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_we |=> ((level == $past(level)) || (level == $past(level) + STEP)
                      || (level == $past(level) - STEP)));  // R10
    AST_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && !load_we && (level >= UP_LIM)) |=> $stable(level));  // R4
    AST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dn && !load_we && (level <= DN_LIM)) |=> $stable(level));  // R5
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_we && !step_up && !step_dn) |=> $stable(level));  // R10

endmodule

// File: rtl/delta_level_unit.sv
module delta_level_unit
    import dlu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_tick,
    input  logic [RATE_W-1:0]  rate_idx,
    input  logic [BYTE_W-1:0]  buf_byte,
    input  logic               buf_full,
    input  logic               load_we,
    input  logic [LEVEL_W-1:0] load_val,
    output logic [LEVEL_W-1:0] level,
    output logic               buf_take
);

    logic fire;
    logic step_up;
    logic step_dn;

    dlu_rate_timer #(.RW(RATE_W), .TW(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_tick (cpu_tick),
        .rate_idx (rate_idx),
        .fire     (fire)
    );

    dlu_frame #(.BW(BYTE_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .buf_full (buf_full),
        .buf_byte (buf_byte),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .buf_take (buf_take)
    );

    dlu_level #(.LW(LEVEL_W)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_we  (load_we),
        .load_val (load_val),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .level    (level)
    );

    AST_NO_SPONTANEOUS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_full |-> !buf_take);  // R3

endmodule

// File: tb/delta_level_unit_bench.sv
`timescale 1ns/1ps
module delta_level_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_tick = 1'b1;
    logic [3:0] rate_idx = 4'hF;
    logic [7:0] buf_byte = 8'h00;
    logic       buf_full = 1'b0;
    logic       load_we = 1'b0;
    logic [6:0] load_val = 7'd0;
    logic [6:0] level;
    logic       buf_take;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int period_tab [16] = '{428, 380, 340, 320, 286, 254, 226, 214,
                            190, 160, 142, 128, 106, 84, 72, 54};
    localparam int PF = 54;

    always #5 clk = ~clk;

    delta_level_unit u_delta_level_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_tick (cpu_tick),
        .rate_idx (rate_idx),
        .buf_byte (buf_byte),
        .buf_full (buf_full),
        .load_we  (load_we),
        .load_val (load_val),
        .level    (level),
        .buf_take (buf_take)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // returns number of ticks waited until buf_take is seen high
    task automatic wait_take(output int waited);
        waited = 0;
        while (buf_take !== 1'b1 && waited < 20000) begin
            tick(1);
            waited++;
        end
    endtask

    function automatic int step_model(input int lvl, input bit b);
        if (b && lvl < 126) return lvl + 2;
        if (!b && lvl > 1)  return lvl - 2;
        return lvl;
    endfunction

    // Plays one byte from a chosen starting level, checking every step
    task automatic run_frame(input logic [7:0] b, input int start, input string req);
        int w;
        int e;
        buf_byte = b;
        buf_full = 1'b1;
        wait_take(w);
        tick(1);                      // past the capturing edge E
        buf_full = 1'b0;
        load_we  = 1'b1;
        load_val = 7'(start);
        tick(1);                      // E+1
        load_we  = 1'b0;
        check("R9 load", int'(level), start);
        tick(PF - 1);                 // E+P: first step
        e = start;
        for (int k = 0; k < 8; k++) begin
            e = step_model(e, b[k]);
            check(req, int'(level), e);
            if (k < 7) tick(PF);
        end
    endtask

    // Measures cycles between level changes with 0x55 streaming
    task automatic measure(input int r, input bit gate);
        int n;
        logic [6:0] prev;
        rate_idx = 4'(r);
        for (int pass = 0; pass < 2; pass++) begin
            prev = level;
            n = 0;
            while (level == prev && n < 5000) begin
                @(posedge clk);
                #1;
                if (gate) cpu_tick = ~cpu_tick;
                n++;
            end
        end
        check(gate ? "R2 gated period" : "R2 period", n,
              gate ? 2 * period_tab[r] : period_tab[r]);
    endtask

    initial begin
        int w;
        int lvl0;
        tick(3);
        check("R1 reset level", int'(level), 0);
        check("R1 reset take", int'(buf_take), 0);
        rst_n = 1'b1;
        // R7: empty buffer, several steps, level stays 0 and no take
        for (int k = 0; k < 10; k++) begin
            tick(PF);
            check("R7 idle level", int'(level), 0);
            check("R7 idle take", int'(buf_take), 0);
        end

        // R4, R5, R6 via full frames
        run_frame(8'hA5, 64, "R6 bit order");
        run_frame(8'h3C, 10, "R6 bit order");
        run_frame(8'hFF, 124, "R4 ceiling even");
        run_frame(8'hFF, 125, "R4 ceiling odd");
        run_frame(8'h00, 3,   "R5 floor odd");
        run_frame(8'h00, 2,   "R5 floor even");

        // R7 + R8: we are just after a frame end with buffer empty
        lvl0 = int'(level);
        for (int k = 0; k < 3; k++) begin
            tick(PF);
            check("R7 silent step", int'(level), lvl0);
        end
        buf_byte = 8'hFF;
        buf_full = 1'b1;              // mid-frame fill, at E8+3P
        wait_take(w);
        check("R8 take waits for frame end", w, 5 * PF - 1);
        check("R7 silent frame level", int'(level), lvl0);
        tick(1);
        buf_full = 1'b0;

        // R9: direct load on the same edge as a step
        buf_byte = 8'hFF;
        buf_full = 1'b1;
        wait_take(w);
        check("R3 take after silent frame", w, 8 * PF - 1);
        tick(1);                      // E
        buf_full = 1'b0;
        load_we  = 1'b1;
        load_val = 7'd60;
        tick(1);                      // E+1
        load_we  = 1'b0;
        tick(PF - 2);                 // E+P-1
        load_we  = 1'b1;
        load_val = 7'd20;
        tick(1);                      // E+P: coincident step
        load_we  = 1'b0;
        check("R9 load wins", int'(level), 20);
        tick(PF - 1);
        check("R10 level held between steps", int'(level), 20);
        tick(1);
        check("R4 step after load", int'(level), 22);

        // R2 sweep: stream 0x55 so the level moves on every step
        buf_byte = 8'h55;
        buf_full = 1'b1;
        load_we  = 1'b1;
        load_val = 7'd64;
        tick(1);
        load_we  = 1'b0;
        for (int r = 0; r < 16; r++) measure(r, 1'b0);
        measure(15, 1'b1);
        measure(13, 1'b1);
        cpu_tick = 1'b1;
        // R3: with buffer always full, takes are 8 periods apart
        rate_idx = 4'hF;
        tick(1000);
        wait_take(w);
        tick(1);
        wait_take(w);
        check("R3 take spacing", w + 1, 8 * PF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule